// File: doc/BRIEF.md
# IQ Signal Strength Estimator

This block measures how strong an incoming complex baseband stream is. It sits after the first decimation stage of a receive chain and takes signed I/Q sample pairs that are qualified by a valid strobe. For each accepted pair it forms the cheap linear magnitude |I| + |Q|. The per-sample magnitudes are summed over a fixed window of master clock cycles. When the window closes, the block divides the window sum by the number of accepted samples and by the full-scale magnitude, and scales the result so that a full-scale input reads 60.

The 6-bit result is kept in an output register. It changes only when a new window result is published, and a one-cycle pulse marks each new value. The window schedule is a free-running divide-by-60 count of the master clock. The accumulator therefore restarts on a fixed cadence, whatever the sample rate.

The division runs as a small sequential state machine with three states:
- `ST_WAIT` idles until the window closes.
- `ST_DIV` produces one quotient bit per cycle, most significant bit first.
- `ST_POST` clamps the quotient and publishes it.

Its transitions are:
- T_CLOSE: `ST_WAIT`→`ST_DIV`, on the last cycle of a window; the window totals are captured.
- T_STEP: `ST_DIV`→`ST_DIV`, while quotient bits remain.
- T_DONE: `ST_DIV`→`ST_POST`, after bit 0.
- T_PUBLISH: `ST_POST`→`ST_WAIT`, unconditionally.
- T_RESET: any state →`ST_WAIT`, on reset.

Top module: `iq_strength_meter`

## Requirements
- R1: For each cycle with `in_valid` high, the sample magnitude is |I| + |Q|, taking I and Q as two's-complement values.
- R2: The absolute value of the most negative input code (-2048 at 12 bits) saturates to the largest positive code (2047), so the magnitude never exceeds the full-scale magnitude 4094.
- R3: The published value is 0 when the window held no valid sample. Otherwise it is min(60, floor(60·S / (N·4094))), where S is the window's magnitude sum and N is its count of valid samples. It never exceeds 60.
- R4: A window is 60 master clock cycles, and its first cycle is the first cycle after reset is released. Every window produces exactly one publication, and consecutive update pulses are exactly 60 cycles apart.
- R5: `upd_o` is high for exactly one cycle, in the same cycle that `rssi_o` first shows the new value.
- R6: `rssi_o` holds its value in every cycle in which `upd_o` is low.
- R7: The sum and count clear at each window boundary. A sample on the last cycle of a window belongs to the closing window, and a sample on the first cycle belongs to the new one.
- R8: A synchronous reset drives `rssi_o` to 0 and `upd_o` to 0, restarts the window count, and discards any result still being computed.
- R9: Cycles with `in_valid` low add nothing to the sum or the count, whatever `in_i` and `in_q` carry.
- R10: A window in which every valid sample is at full scale on both channels publishes 60.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_i` and `in_q` in this cycle |
| in_i | input | 12 | In-phase sample, two's complement |
| in_q | input | 12 | Quadrature sample, two's complement |
| rssi_o | output | 6 | Registered strength code, 0 to 60 |
| upd_o | output | 1 | One-cycle pulse marking a new `rssi_o` value |

## Verification
Two functions can act in the same cycle: closing a window and accepting a sample. The cycle that ends a window also captures the totals for division and clears the accumulator. This coincidence is provoked by a window whose only valid sample sits on its last cycle, followed by a window whose only valid sample sits on its first cycle, with magnitudes chosen so that each published code shows which window received the sample. A second coincidence is a reset that arrives while a division is in flight. It is judged by requiring that no stale result is ever published afterwards.

// File: rtl/iqsm_pkg.sv
package iqsm_pkg;
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_DIV  = 2'd1,
        ST_POST = 2'd2
    } div_state_e;
endpackage

// File: rtl/iqsm_absmag.sv
module iqsm_absmag #(
    parameter int SAMP_W = 12
) (
    input  logic signed [SAMP_W-1:0] i_in,
    input  logic signed [SAMP_W-1:0] q_in,
    output logic        [SAMP_W-1:0] mag
);
    localparam int A_W = SAMP_W - 1;

    logic signed [SAMP_W-1:0] chan [2];
    logic        [A_W-1:0]    mag_ch [2];

    assign chan[0] = i_in;
    assign chan[1] = q_in;

    for (genvar c = 0; c < 2; c++) begin : g_chan
        logic signed [SAMP_W-1:0] neg;
        assign neg = -chan[c];
        always_comb begin
            if (chan[c][SAMP_W-1]) begin
                // the lowest code has no positive twin: pin it to the top code
                if (neg[SAMP_W-1]) mag_ch[c] = {A_W{1'b1}};
                else               mag_ch[c] = neg[A_W-1:0];
            end else begin
                mag_ch[c] = chan[c][A_W-1:0];
            end
        end
    end

    assign mag = {1'b0, mag_ch[0]} + {1'b0, mag_ch[1]};
endmodule

// File: rtl/iqsm_window.sv
module iqsm_window #(
    parameter int WIN_LEN = 60
) (
    input  logic clk,
    input  logic rst,
    output logic last
);
    localparam int CNT_W = $clog2(WIN_LEN);

    logic [CNT_W-1:0] cnt;

    assign last = (cnt == CNT_W'(WIN_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst || last) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/iqsm_accum.sv
module iqsm_accum #(
    parameter int MAG_W   = 12,
    parameter int WIN_LEN = 60,
    localparam int N_W    = $clog2(WIN_LEN + 1),
    localparam int ACC_W  = MAG_W + N_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic [MAG_W-1:0] mag,
    input  logic             last,
    output logic [ACC_W-1:0] sum_fin,
    output logic [N_W-1:0]   n_fin
);
    logic [ACC_W-1:0] acc;
    logic [N_W-1:0]   n;
    logic [MAG_W-1:0] add;

    assign add     = valid ? mag : '0;
    assign sum_fin = acc + ACC_W'(add);
    assign n_fin   = n + N_W'(valid);

    always_ff @(posedge clk) begin
        if (rst || last) begin
            acc <= '0;
            n   <= '0;
        end else begin
            acc <= sum_fin;
            n   <= n_fin;
        end
    end
endmodule

// File: rtl/iqsm_divfsm.sv
module iqsm_divfsm
    import iqsm_pkg::*;
#(
    parameter int ACC_W     = 18,
    parameter int N_W       = 6,
    parameter int OUT_W     = 6,
    parameter int FULL_CODE = 60,
    parameter int MAG_FS    = 4094
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             close,
    input  logic [ACC_W-1:0] sum_fin,
    input  logic [N_W-1:0]   n_fin,
    output logic [OUT_W-1:0] rssi,
    output logic             upd
);
    localparam int SC_W  = $clog2(FULL_CODE + 1);
    localparam int DW    = ACC_W + SC_W + N_W + OUT_W;
    localparam int BIT_W = (OUT_W > 1) ? $clog2(OUT_W) : 1;

    div_state_e       state_q, state_d;
    logic [DW-1:0]    rem_q, den_q, trial;
    logic [OUT_W-1:0] quo_q;
    logic [BIT_W-1:0] bit_q;
    logic             empty_q;

    assign trial = den_q << bit_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_WAIT;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: if (close) state_d = ST_DIV;
            ST_DIV:  if (bit_q == '0) state_d = ST_POST;
            ST_POST: state_d = ST_WAIT;
            default: state_d = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rssi    <= '0;
            upd     <= 1'b0;
            rem_q   <= '0;
            den_q   <= '0;
            quo_q   <= '0;
            bit_q   <= '0;
            empty_q <= 1'b0;
        end else begin
            upd <= 1'b0;
            unique case (state_q)
                ST_WAIT: begin
                    if (close) begin
                        rem_q   <= DW'(sum_fin) * DW'(FULL_CODE);
                        den_q   <= DW'(n_fin) * DW'(MAG_FS);
                        quo_q   <= '0;
                        bit_q   <= BIT_W'(OUT_W - 1);
                        empty_q <= (n_fin == '0);
                    end
                end
                ST_DIV: begin
                    if (rem_q >= trial) begin
                        rem_q        <= rem_q - trial;
                        quo_q[bit_q] <= 1'b1;
                    end
                    bit_q <= bit_q - 1'b1;
                end
                ST_POST: begin
                    if (empty_q)                      rssi <= '0;
                    else if (quo_q > OUT_W'(FULL_CODE)) rssi <= OUT_W'(FULL_CODE);
                    else                              rssi <= quo_q;
                    upd <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/iq_strength_meter.sv
module iq_strength_meter #(
    parameter int SAMP_W    = 12,
    parameter int WIN_LEN   = 60,
    parameter int FULL_CODE = 60,
    parameter int OUT_W     = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [SAMP_W-1:0] in_i,
    input  logic [SAMP_W-1:0] in_q,
    output logic [OUT_W-1:0]  rssi_o,
    output logic              upd_o
);
    localparam int MAG_W  = SAMP_W;
    localparam int MAG_FS = 2 * (2 ** (SAMP_W - 1) - 1);
    localparam int N_W    = $clog2(WIN_LEN + 1);
    localparam int ACC_W  = MAG_W + N_W;

    logic [MAG_W-1:0] mag_w;
    logic             last_w;
    logic [ACC_W-1:0] sum_w;
    logic [N_W-1:0]   n_w;

    iqsm_absmag #(.SAMP_W(SAMP_W)) u_mag (
        .i_in (in_i),
        .q_in (in_q),
        .mag  (mag_w)
    );

    iqsm_window #(.WIN_LEN(WIN_LEN)) u_win (
        .clk  (clk),
        .rst  (rst),
        .last (last_w)
    );

    iqsm_accum #(.MAG_W(MAG_W), .WIN_LEN(WIN_LEN)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .valid   (in_valid),
        .mag     (mag_w),
        .last    (last_w),
        .sum_fin (sum_w),
        .n_fin   (n_w)
    );

    iqsm_divfsm #(
        .ACC_W     (ACC_W),
        .N_W       (N_W),
        .OUT_W     (OUT_W),
        .FULL_CODE (FULL_CODE),
        .MAG_FS    (MAG_FS)
    ) u_div (
        .clk     (clk),
        .rst     (rst),
        .close   (last_w),
        .sum_fin (sum_w),
        .n_fin   (n_w),
        .rssi    (rssi_o),
        .upd     (upd_o)
    );
endmodule

// File: rtl/iq_strength_meter_chk.sv
module iq_strength_meter_chk #(
    parameter int SAMP_W    = 12,
    parameter int WIN_LEN   = 60,
    parameter int FULL_CODE = 60,
    parameter int OUT_W     = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [OUT_W-1:0]  rssi_o,
    input logic              upd_o,
    input logic [SAMP_W-1:0] mag
);
    localparam int MAG_FS = 2 * (2 ** (SAMP_W - 1) - 1);
    localparam int G_W    = $clog2(WIN_LEN) + 2;

    logic [G_W-1:0] gap;
    logic           seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (upd_o) begin
            gap  <= '0;
            seen <= 1'b1;
        end else if (gap != '1) begin
            gap <= gap + 1'b1;
        end
    end

    p_mag_cap_r2: assert property (@(posedge clk) disable iff (rst)
        mag <= SAMP_W'(MAG_FS));

    p_code_max_r3: assert property (@(posedge clk) disable iff (rst)
        rssi_o <= OUT_W'(FULL_CODE));

    p_period_r4: assert property (@(posedge clk) disable iff (rst)
        (upd_o && seen) |-> (gap == G_W'(WIN_LEN - 1)));

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        upd_o |=> !upd_o);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !upd_o |-> $stable(rssi_o));

    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (rssi_o == '0 && !upd_o));
endmodule

bind iq_strength_meter iq_strength_meter_chk #(
    .SAMP_W    (SAMP_W),
    .WIN_LEN   (WIN_LEN),
    .FULL_CODE (FULL_CODE),
    .OUT_W     (OUT_W)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .rssi_o (rssi_o),
    .upd_o  (upd_o),
    .mag    (mag_w)
);

// File: tb/sim_iq_strength_meter.sv
module sim_iq_strength_meter;
    localparam int SW  = 12;
    localparam int WIN = 60;
    localparam int FS  = 4094;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [SW-1:0] in_i = '0;
    logic [SW-1:0] in_q = '0;
    logic [5:0]    rssi_o;
    logic          upd_o;

    int     nchk = 0;
    int     nerr = 0;
    int     exp_q[$];
    longint acc_s = 0;
    int     acc_n = 0;
    int     widx = 0;
    int     cyc = 0;
    int     prev_cyc = 0;
    bit     have_prev = 0;
    bit     prev_upd = 0;
    int     last_code = 0;
    bit     done = 0;

    iq_strength_meter u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q), .rssi_o(rssi_o), .upd_o(upd_o)
    );

    always #2 clk = ~clk;

    function automatic int sabs(input int v);
        if (v == -2048) return 2047;
        return (v < 0) ? -v : v;
    endfunction

    function automatic int exp_code(input longint s, input int n);
        longint v;
        if (n == 0) return 0;
        v = (s * 60) / (n * FS);
        return (v > 60) ? 60 : int'(v);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic drive(input bit v, input int iv, input int qv);
        @(negedge clk);
        in_valid = v;
        in_i = SW'(iv);
        in_q = SW'(qv);
        if (v) begin
            acc_s += sabs(iv) + sabs(qv);
            acc_n++;
        end
        widx++;
        if (widx == WIN) begin
            exp_q.push_back(exp_code(acc_s, acc_n));
            acc_s = 0;
            acc_n = 0;
            widx = 0;
        end
    endtask

    // R8: reset clears the output and the pending result, and restarts the window
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        exp_q.delete();
        acc_s = 0;
        acc_n = 0;
        repeat (3) @(negedge clk);
        chk(rssi_o == 0, "R8 rssi in reset", int'(rssi_o), 0);
        chk(upd_o == 0, "R8 pulse in reset", int'(upd_o), 0);
        have_prev = 0;
        prev_upd = 0;
        last_code = 0;
        rst = 1'b0;
        widx = 1;  // this cycle is window slot 0, carrying no sample
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst && !done) begin
            if (prev_upd) chk(!upd_o, "R5 pulse width", int'(upd_o), 0);
            if (upd_o) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected pulse", int'(rssi_o), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(int'(rssi_o) == e, "R3 window code", int'(rssi_o), e);
                end
                if (have_prev) chk(cyc - prev_cyc == WIN, "R4 pulse spacing", cyc - prev_cyc, WIN);
                have_prev = 1;
                prev_cyc = cyc;
            end else begin
                chk(int'(rssi_o) == last_code, "R6 hold", int'(rssi_o), last_code);
            end
            prev_upd = upd_o;
            last_code = int'(rssi_o);
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd4711);
        do_reset();
        // first window: slot 0 already used by reset release
        for (int k = 1; k < WIN; k++) drive(1'b1, 0, 0);            // R1 zero -> 0
        for (int k = 0; k < WIN; k++) drive(1'b1, 2047, 2047);      // R10 full scale -> 60
        for (int k = 0; k < WIN; k++) drive(1'b1, -2048, -2048);    // R2 saturation -> 60
        for (int k = 0; k < WIN; k++) drive(1'b1, 2047, -2048);     // R2 mixed -> 60
        for (int k = 0; k < WIN; k++) drive(1'b1, 1000, -500);      // R1 -> 21
        for (int k = 0; k < WIN; k++) drive(1'b0, 2047, -2048);     // R9 no valid -> 0
        for (int k = 0; k < WIN; k++)                               // R9 ignored junk -> 0
            if (k % 3 == 0) drive(1'b1, 0, 0); else drive(1'b0, 2047, 2047);
        // R7: sample on the last slot, then on the first slot of the next window
        for (int k = 0; k < WIN; k++)
            if (k == WIN - 1) drive(1'b1, 2047, 2047); else drive(1'b0, 0, 0);
        for (int k = 0; k < WIN; k++)
            if (k == 0) drive(1'b1, 100, 0); else drive(1'b0, 2047, 2047);
        // R8: reset while a division for a full-scale window is pending
        for (int k = 0; k < WIN; k++) drive(1'b1, 2047, 2047);
        repeat (3) drive(1'b1, 5, 5);
        do_reset();
        for (int k = 1; k < WIN; k++) drive(1'b1, -300, 700);       // R1 after reset -> 14
        // random windows
        for (int w = 0; w < 40; w++) begin
            int dens;
            dens = int'($urandom_range(0, 4));
            for (int k = 0; k < WIN; k++) begin
                int iv, qv;
                bit v;
                iv = int'($urandom_range(0, 4095)) - 2048;
                qv = int'($urandom_range(0, 4095)) - 2048;
                if ($urandom_range(0, 15) == 0) iv = -2048;
                v = (int'($urandom_range(0, 3)) < dens);
                drive(v, iv, qv);
            end
        end
        repeat (20) @(negedge clk);
        in_valid = 1'b0;
        chk(exp_q.size() == 0, "R4 every window published", exp_q.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule